// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block tells an asynchronous DRAM cycle sequencer when to run refresh cycles, and it holds off normal memory traffic until the device has been brought up. After reset it counts out a start-up quiet period of 200 µs. It then asks for eight bring-up refresh cycles. Either refresh flavour satisfies a request: CAS-before-RAS, which needs no row address, or RAS-only with a row that the sequencer supplies. Once the eighth of these is acknowledged, the block raises its ready flag. From then on it keeps a steady rhythm of refresh requests, spaced so that all 4096 rows are covered inside the 64 ms retention window.

The sequencer sees a level request and answers with a one-cycle acknowledge each time it runs a refresh. If the sequencer falls behind, periodic refreshes that come due are not lost. They pile up in a saturating backlog counter, and that count is visible on an output. The block also gates host access grants and passes none while the memory is not yet ready. The clock frequency is a parameter, and all cycle counts are derived from it.

Top module: `dram_ref_sched`

## Requirements
- R1: With reset held and in the cycles that follow it, `ref_req`, `ready`, `pending` and `host_gnt` read 0. `ref_req` first reads 1 after exactly STARTUP_CYC rising edges with reset low. STARTUP_CYC is floor(CLK_HZ × 200 µs), which is 10000 at 50 MHz.
- R2: When the start-up delay ends, `pending` becomes 8 and `ref_req` goes high at the same edge. During bring-up, each accepted acknowledge lowers `pending` by one. An acknowledge is accepted when `ref_ack` is 1 at a rising edge while `ref_req` is 1.
- R3: `ready` rises at the edge that accepts the eighth bring-up acknowledge, and `pending` reads 0 at that edge. `ready` then stays high until reset.
- R4: No periodic refresh comes due before `ready`. The first one comes due exactly INTERVAL edges after the edge that raised `ready`, and later ones follow every INTERVAL edges whatever the acknowledge activity. INTERVAL is floor(CLK_HZ × 64 ms / 4096), which is 781 at 50 MHz.
- R5: In normal operation, a due refresh with no accepted acknowledge at that edge raises `pending` by one. A due refresh together with an accepted acknowledge leaves `pending` unchanged. An accepted acknowledge alone lowers it by one. `pending` never goes above 8, and a due refresh at 8 leaves it at 8.
- R6: `ref_req` is 1 exactly when `pending` is nonzero, and both change at the same edge.
- R7: When `ref_req` is 0, `ref_ack` has no effect: `pending` stays 0 unless a refresh comes due at that edge.
- R8: `host_gnt` equals `host_req` delayed by one edge, ANDed with `ready` as it was before that edge. It is 0 whenever `ready` was 0.
- R9: A synchronous reset asserted at any time clears every output and counter, and the start-up delay of R1 starts again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| ref_req | output | 1 | A refresh is owed (level) |
| ref_ack | input | 1 | Sequencer ran one refresh (one-cycle pulse) |
| pending | output | PCW (4) | Number of refreshes owed |
| ready | output | 1 | Bring-up complete, normal access allowed |
| host_req | input | 1 | Host asks for an access slot |
| host_gnt | output | 1 | Host access granted (registered) |

## Verification
The bring-up path is run with acknowledges that come at random latencies. Its exact start-up edge count and the point where `ready` rises show whether the delay and the bring-up count are off by one. Normal operation is tried in several ways, and each one separates a different rule. A sequencer that never answers drives the backlog into saturation. An always-asserted acknowledge drains the backlog and then keeps hitting an idle request, which exposes any miscounted stray acknowledge. Random acknowledges mix increments, decrements and coincidences. One directed acknowledge is placed exactly on a due edge to check the hold-on-coincidence rule. A reset in mid-operation confirms that the whole delay starts again.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } ref_phase_e;

  // Clock cycles in a span of microseconds, rounded down.
  function automatic int unsigned us_to_cycles(longint unsigned hz, longint unsigned us);
    return int'((hz * us) / 64'd1000000);
  endfunction

  // Average spacing of refreshes: retention window split over all rows.
  function automatic int unsigned refresh_spacing(longint unsigned hz, longint unsigned ms,
                                                  longint unsigned rows);
    return int'((hz * ms) / (64'd1000 * rows));
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_startup_timer.sv
module ref_startup_timer #(
  parameter int unsigned CYC = 10000,
  localparam int unsigned CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!last)  cnt_q <= cnt_q + 1'b1;
  end

  // R1: counter never passes its terminal value
  assert_startup_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CYC - 1));
endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned CYC = 781,
  localparam int unsigned CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R4: the spacing counter rests at zero whenever it is not enabled
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0) || en);
endmodule

// File: rtl/ref_pending_ctr.sv
module ref_pending_ctr #(
  parameter int unsigned MAXC = 8,
  parameter int unsigned W    = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count_q,
  output logic         req_q
);
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (load) begin
      count_d = load_val;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (count_q < W'(MAXC)) count_d = count_q + 1'b1;
        2'b01:   if (count_q != '0)      count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      req_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      req_q   <= (count_d != '0);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !load && count_q == W'(MAXC)) |=> count_q == W'(MAXC));
  assert_inc_step_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && !load && count_q < W'(MAXC)) |=> count_q == $past(count_q) + 1'b1);
  assert_coincide_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !load) |=> $stable(count_q));
  assert_req_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    req_q == (count_q != '0));
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned STARTUP_US   = 200,
  parameter int unsigned RETENTION_MS = 64,
  parameter int unsigned ROWS         = 4096,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned PEND_MAX     = 8,
  localparam int unsigned PCW = $clog2(max_u(PEND_MAX, INIT_CYCLES) + 1)
) (
  input  logic           clk,
  input  logic           rst,
  output logic           ref_req,
  input  logic           ref_ack,
  output logic [PCW-1:0] pending,
  output logic           ready,
  input  logic           host_req,
  output logic           host_gnt
);
  localparam int unsigned STARTUP_CYC = us_to_cycles(CLK_HZ, STARTUP_US);
  localparam int unsigned INTERVAL    = refresh_spacing(CLK_HZ, RETENTION_MS, ROWS);

  ref_phase_e phase_q;
  logic       wait_done, tick_w, ack_ok, init_load, init_last;

  ref_startup_timer #(.CYC(STARTUP_CYC)) u_start (
    .clk (clk), .rst (rst), .run (phase_q == PH_WAIT), .last (wait_done)
  );

  ref_interval_timer #(.CYC(INTERVAL)) u_itv (
    .clk (clk), .rst (rst), .en (phase_q == PH_RUN), .tick (tick_w)
  );

  assign ack_ok    = ref_ack && ref_req;
  assign init_load = wait_done;
  assign init_last = (phase_q == PH_INIT) && ack_ok && (pending == PCW'(1));

  ref_pending_ctr #(.MAXC(PEND_MAX), .W(PCW)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .load     (init_load),
    .load_val (PCW'(INIT_CYCLES)),
    .inc      (tick_w),
    .dec      (ack_ok),
    .count_q  (pending),
    .req_q    (ref_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_WAIT;
      ready    <= 1'b0;
      host_gnt <= 1'b0;
    end else begin
      host_gnt <= host_req && ready;
      unique case (phase_q)
        PH_WAIT: if (wait_done) phase_q <= PH_INIT;
        PH_INIT: if (init_last) begin
          phase_q <= PH_RUN;
          ready   <= 1'b1;
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assert_no_req_in_wait_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WAIT) |-> !ref_req);
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_no_tick_before_ready_R4: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !tick_w);
  assert_stray_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (!ref_req && ref_ack && !tick_w && !wait_done) |=> (pending == '0));
  assert_gnt_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !host_gnt);
endmodule

// File: tb/dram_ref_sched_test.sv
module dram_ref_sched_test;
  localparam int S = 50_000 * 200 / 1000;   // 200 us at 50 MHz
  localparam int I = 50_000 * 64 / 4096;    // 64 ms / 4096 rows at 50 MHz
  localparam int PMAX = 8;

  logic clk = 1'b0, rst = 1'b1, ref_ack = 1'b0, host_req = 1'b0;
  logic ref_req, ready, host_gnt;
  logic [3:0] pending;

  dram_ref_sched uut (
    .clk(clk), .rst(rst), .ref_req(ref_req), .ref_ack(ref_ack),
    .pending(pending), .ready(ready), .host_req(host_req), .host_gnt(host_gnt)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int mode = 0;          // 0 no ack, 1 random ack, 2 ack always, 3 manual
  logic man_ack = 1'b0;

  // Reference model built from the requirements
  int m_phase = 0, m_cnt = 0, m_itv = 0, m_pend = 0;
  bit m_ready = 0, m_gnt = 0;
  always @(posedge clk) begin
    bit acc, tk;
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_itv = 0; m_pend = 0; m_ready = 0; m_gnt = 0;
    end else begin
      m_gnt = host_req && m_ready;
      acc = ref_ack && (m_pend != 0);
      case (m_phase)
        0: if (m_cnt == S - 1) begin m_phase = 1; m_pend = 8; end else m_cnt++;
        1: if (acc) begin
             m_pend--;
             if (m_pend == 0) begin m_phase = 2; m_ready = 1; m_itv = 0; end
           end
        default: begin
          tk = (m_itv == I - 1);
          m_itv = tk ? 0 : m_itv + 1;
          if (tk && !acc && m_pend < PMAX) m_pend++;
          else if (!tk && acc) m_pend--;
        end
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R6 ref_req", ref_req, m_pend != 0);
    chk("R5 pending", pending, m_pend);
    chk("R3 ready", ready, m_ready);
    chk("R8 host_gnt", host_gnt, m_gnt);
    case (mode)
      0: ref_ack = 1'b0;
      1: ref_ack = ($urandom % 3) == 0;
      2: ref_ack = 1'b1;
      default: ref_ack = man_ack;
    endcase
    host_req = $urandom % 2;
  endtask

  task automatic startup_count(string tag);
    int n = 0;
    do begin step(); n++; end while (!ref_req && n < S + 10);
    chk(tag, n, S);
    chk("R2 init pending", pending, 8);
  endtask

  initial begin
    void'($urandom(32'd1234));
    mode = 0;
    repeat (4) step();
    chk("R1 reset ref_req", ref_req, 0);
    chk("R1 reset ready", ready, 0);
    chk("R1 reset pending", pending, 0);
    chk("R1 reset host_gnt", host_gnt, 0);
    rst = 1'b0;
    startup_count("R1 startup edges");

    // bring-up with random acknowledge latency
    mode = 1;
    do step(); while (!ready);
    chk("R3 pending at ready", pending, 0);

    // first periodic request spacing
    mode = 0;
    begin
      int n = 0;
      do begin step(); n++; end while (!ref_req && n < I + 10);
      chk("R4 first interval", n, I);
    end
    // next spacing while nothing acknowledged
    begin
      int n = 0;
      do begin step(); n++; end while (pending != 2 && n < I + 10);
      chk("R4 second interval", n, I);
    end

    // saturation with a silent sequencer
    repeat (9 * I) step();
    chk("R5 saturated", pending, PMAX);
    chk("R6 req while saturated", ref_req, 1);

    // drain, then stray acknowledges on an idle request
    mode = 2;
    do step(); while (pending != 0);
    chk("R6 req low after drain", ref_req, 0);
    step();
    chk("R7 stray ack ignored", pending, 0);

    // due edge coinciding with an accepted acknowledge
    mode = 3; man_ack = 1'b0;
    do step(); while (!ref_req);
    for (int j = 1; j < I; j++) begin
      man_ack = (j == I - 1);
      step();
    end
    man_ack = 1'b0;
    step();
    chk("R5 coincidence holds", pending, 1);

    // random traffic
    mode = 1;
    repeat (25 * I) step();

    // mid-run synchronous reset
    mode = 0;
    repeat (3 * I) step();
    rst = 1'b1;
    step(); step();
    chk("R9 reset pending", pending, 0);
    chk("R9 reset ready", ready, 0);
    chk("R9 reset ref_req", ref_req, 0);
    rst = 1'b0;
    startup_count("R9 restart edges");
    mode = 1;
    do step(); while (!ready);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule